// File: doc/BRIEF.md
# Memory Bus Bandwidth Monitor

The block watches a memory bus and measures how much data it moves over fixed measurement windows. Each cycle a strobe may present one transfer, tagged with the requesting master and carrying a byte count. A prescaler turns the bus clock into a slower tick, and a window lasts a programmed number of ticks. If the prescale value is set to the bus clock in MHz minus one, one tick is one microsecond.

For each master, and for the bus as a whole, the block adds up the traffic of the current window in a selectable unit: bytes, KiB or MiB. When a window closes it keeps the larger of the stored peak and that window's sum, then starts the next window at zero. Software reads the peaks through a small word-addressed register port. A governor divides the total peak by the nominal capacity of one window to get the bus load. Every counter clears only when the enable bit is written from 0 to 1.

Top module: `bwm_monitor`

## Requirements
- R1: After reset every mapped register reads 0.
- R2: Word 0 holds the prescale value (divider minus one) in its low PRESC_W bits. Word 1 is the configuration word. Its bits [31:16] hold the window length in ticks minus one, bits [2:1] the unit and bit 0 the enable. Both words read back what was written, and unused bits read 0.
- R3: A tick occurs every prescale+1 enabled cycles. A window spans window-field+1 ticks, so it closes (prescale+1)*(window+1) cycles after the enabling write. A transfer in the closing cycle belongs to the closing window. The new peak is visible to a read issued in the cycle after the close.
- R4: At each window close the peak becomes the larger of the old peak and the window sum, and the window sum restarts at zero.
- R5: Unit code 0 counts bytes, 1 counts KiB (1024 bytes) and 2 counts MiB (1048576 bytes). Code 3 counts bytes. Bytes below one unit carry into later transfers and across window boundaries, so no bytes are lost.
- R6: Words 2 to 2+N_MASTERS-1 return the peaks for master ids 0 to N_MASTERS-1. Each of them counts only its own id. Word 2+N_MASTERS returns the peak of all traffic.
- R7: Writing the configuration word with the enable bit set while the block is disabled clears every counter and timer. Writing it with the enable bit set while already enabled clears nothing.
- R8: While disabled, transfer strobes are ignored and all peaks hold their values.
- R9: A window sum saturates at 2^CNT_W-1 instead of wrapping.
- R10: A read of an address outside words 0 to 2+N_MASTERS returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; data appears on the following cycle |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| xfer_vld | input | 1 | A transfer occurs this cycle |
| xfer_id | input | ID_W | Master issuing the transfer |
| xfer_bytes | input | BYTES_W | Bytes moved by the transfer |

## Verification
A corrupted window sum or sub-unit remainder stays hidden until the window closes. It then shows as a wrong peak, which can be read from the cycle after the close. The checks therefore read each peak just before and just after a known close cycle. A prescale or window counter that is off by one moves that close by whole cycles, so a read placed exactly at the boundary returns the old peak where it should already hold the new one. A remainder that is dropped shows only in a later window, as a KiB or MiB total that falls short by one.

// File: rtl/bwm_pkg.sv
`timescale 1ns/1ps
package bwm_pkg;
  typedef enum logic [1:0] {
    UNIT_BYTE = 2'd0,
    UNIT_KIB  = 2'd1,
    UNIT_MIB  = 2'd2,
    UNIT_ALT  = 2'd3
  } bwm_unit_e;

  localparam int KIB_SH = 10;
  localparam int MIB_SH = 20;
  localparam int FRAC_W = MIB_SH;
  localparam int WIN_W  = 16;

  localparam int REG_PRESC = 0;
  localparam int REG_CFG   = 1;
  localparam int REG_CHAN0 = 2;
endpackage

// File: rtl/bwm_timebase.sv
`timescale 1ns/1ps
module bwm_timebase #(
  parameter int PRESC_W = 16,
  parameter int WIN_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               clr,
  input  logic [PRESC_W-1:0] presc_lim,
  input  logic [WIN_W-1:0]   win_lim,
  output logic               tick,
  output logic               win_end
);
  logic [PRESC_W-1:0] presc_cnt;
  logic [WIN_W-1:0]   win_cnt;

  // >= keeps the counters bounded if a limit is lowered mid-window
  assign tick    = run && (presc_cnt >= presc_lim);
  assign win_end = tick && (win_cnt >= win_lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      presc_cnt <= '0;
      win_cnt   <= '0;
    end else if (run) begin
      if (tick) begin
        presc_cnt <= '0;
        if (win_end) win_cnt <= '0;
        else         win_cnt <= win_cnt + 1'b1;
      end else begin
        presc_cnt <= presc_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bwm_chan.sv
`timescale 1ns/1ps
module bwm_chan
  import bwm_pkg::*;
#(
  parameter int BYTES_W = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               clr,
  input  bwm_unit_e          unit,
  input  logic               add_vld,
  input  logic [BYTES_W-1:0] add_bytes,
  input  logic               win_end,
  output logic [CNT_W-1:0]   peak
);
  localparam int SUM_W = ((CNT_W > FRAC_W + 1) ? CNT_W : FRAC_W + 1) + 1;
  localparam logic [SUM_W-1:0] SAT = SUM_W'({CNT_W{1'b1}});

  logic [FRAC_W-1:0] frac_q, frac_nx;
  logic [FRAC_W:0]   raw, units;
  logic [CNT_W-1:0]  win_q, win_nx;
  logic [SUM_W-1:0]  wide;

  always_comb begin
    raw = (FRAC_W+1)'(frac_q);
    if (add_vld) raw = raw + (FRAC_W+1)'(add_bytes);
    case (unit)
      UNIT_KIB: begin
        units   = raw >> KIB_SH;
        frac_nx = FRAC_W'(raw[KIB_SH-1:0]);
      end
      UNIT_MIB: begin
        units   = raw >> MIB_SH;
        frac_nx = raw[FRAC_W-1:0];
      end
      default: begin
        units   = raw;
        frac_nx = '0;
      end
    endcase
    wide   = SUM_W'(win_q) + SUM_W'(units);
    win_nx = (wide > SAT) ? {CNT_W{1'b1}} : wide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      frac_q <= '0;
      win_q  <= '0;
      peak   <= '0;
    end else if (run) begin
      frac_q <= frac_nx;
      if (win_end) begin
        win_q <= '0;
        if (win_nx > peak) peak <= win_nx;
      end else begin
        win_q <= win_nx;
      end
    end
  end
endmodule

// File: rtl/bwm_monitor.sv
`timescale 1ns/1ps
module bwm_monitor
  import bwm_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int BYTES_W   = 8,
  parameter int CNT_W     = 32,
  parameter int PRESC_W   = 16,
  parameter int ADDR_W    = 4,
  localparam int ID_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               xfer_vld,
  input  logic [ID_W-1:0]    xfer_id,
  input  logic [BYTES_W-1:0] xfer_bytes
);
  localparam int NCH = N_MASTERS + 1;

  logic [PRESC_W-1:0] presc_q;
  logic [WIN_W-1:0]   win_q;
  bwm_unit_e          unit_q;
  logic               en_q;
  logic               cfg_wr, clr_pulse, tick, win_end;
  logic [CNT_W-1:0]   peak [NCH];
  logic [CNT_W-1:0]   tot_peak;
  logic [31:0]        rd_nx;

  assign cfg_wr    = reg_we && (reg_addr == ADDR_W'(REG_CFG));
  assign clr_pulse = cfg_wr && reg_wdata[0] && !en_q;
  assign tot_peak  = peak[N_MASTERS];

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      win_q   <= '0;
      unit_q  <= UNIT_BYTE;
      en_q    <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(REG_PRESC)) presc_q <= reg_wdata[PRESC_W-1:0];
      if (cfg_wr) begin
        win_q  <= reg_wdata[31:16];
        unit_q <= bwm_unit_e'(reg_wdata[2:1]);
        en_q   <= reg_wdata[0];
      end
    end
  end

  bwm_timebase #(.PRESC_W(PRESC_W), .WIN_W(WIN_W)) u_tb (
    .clk(clk), .rst(rst), .run(en_q), .clr(clr_pulse),
    .presc_lim(presc_q), .win_lim(win_q), .tick(tick), .win_end(win_end)
  );

  for (genvar m = 0; m < NCH; m++) begin : g_ch
    logic hit;
    if (m == N_MASTERS) begin : g_all
      assign hit = xfer_vld;
    end else begin : g_one
      assign hit = xfer_vld && (xfer_id == ID_W'(m));
    end
    bwm_chan #(.BYTES_W(BYTES_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .run(en_q), .clr(clr_pulse), .unit(unit_q),
      .add_vld(hit), .add_bytes(xfer_bytes), .win_end(win_end),
      .peak(peak[m])
    );
  end

  always_comb begin
    rd_nx = '0;
    if (reg_addr == ADDR_W'(REG_PRESC)) rd_nx = 32'(presc_q);
    if (reg_addr == ADDR_W'(REG_CFG))
      rd_nx = {win_q, 13'd0, unit_q, en_q};
    for (int m = 0; m < NCH; m++)
      if (reg_addr == ADDR_W'(REG_CHAN0 + m)) rd_nx = 32'(peak[m]);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_nx;
  end
endmodule

// File: rtl/bwm_checker.sv
`timescale 1ns/1ps
module bwm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             clr,
  input logic             tick,
  input logic             win_end,
  input logic [CNT_W-1:0] tot_peak
);
  assert_tick_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    tick |-> en);

  assert_close_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    win_end |-> tick);

  assert_peak_no_drop_R4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> tot_peak >= $past(tot_peak));

  assert_clear_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> tot_peak == '0);

  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(tot_peak));
endmodule

bind bwm_monitor bwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en_q), .clr(clr_pulse),
  .tick(tick), .win_end(win_end), .tot_peak(tot_peak)
);

// File: tb/sim_bwm_monitor.sv
`timescale 1ns/1ps
module sim_bwm_monitor;
  localparam int NM = 4;
  localparam int CW = 12;
  localparam int AW = 4;
  localparam int A_TOT = 2 + NM;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_vld = 1'b0;
  logic [1:0]  xfer_id = '0;
  logic [7:0]  xfer_bytes = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bwm_monitor #(.N_MASTERS(NM), .BYTES_W(8), .CNT_W(CW), .PRESC_W(16), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_vld(xfer_vld),
    .xfer_id(xfer_id), .xfer_bytes(xfer_bytes)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_re = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic xfer(input int id, input int bytes, input int n);
    xfer_vld = 1'b1; xfer_id = 2'(id); xfer_bytes = 8'(bytes);
    repeat (n) @(negedge clk);
    xfer_vld = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a <= A_TOT; a++) rd_chk("R1 reset value", a, 0);
  endtask

  task automatic t_regmap();
    wr(0, 32'd5);
    rd_chk("R2 prescale readback", 0, 32'd5);
    wr(1, 32'hFFFF_FFFC);
    rd_chk("R2 config readback", 1, 32'hFFFF_0004);
    rd_chk("R10 unmapped word", A_TOT + 1, 0);
    rd_chk("R10 top word", 15, 0);
  endtask

  task automatic t_timing();
    wr(1, 32'h0);
    wr(0, 32'd3);
    wr(1, 32'h0001_0001);     // window 2 ticks, 4 cycles/tick -> close at E8
    xfer(0, 10, 1);
    idle(6);
    rd_chk("R3 peak not yet updated at close edge", A_TOT, 0);
    rd_chk("R3 peak after close", A_TOT, 10);
  endtask

  task automatic t_peak();
    wr(1, 32'h0002_0000);
    wr(0, 32'd1);
    wr(1, 32'h0002_0001);     // 6-cycle windows
    xfer(0, 100, 3);
    idle(3);
    rd_chk("R4 first window peak", A_TOT, 300);
    xfer(1, 100, 5);
    rd_chk("R4 larger window raises peak", A_TOT, 500);
    xfer(2, 50, 1);
    idle(5);
    rd_chk("R4 sum restarts, smaller window keeps peak", A_TOT, 500);
    rd_chk("R6 master 0 peak", 2, 300);
    rd_chk("R6 master 1 peak", 3, 500);
    rd_chk("R6 master 2 peak", 4, 50);
    rd_chk("R6 master 3 untouched", 5, 0);
  endtask

  task automatic t_rewrite();
    wr(1, 32'h0002_0001);
    idle(8);
    rd_chk("R7 enable rewrite keeps peak", A_TOT, 500);
    wr(1, 32'h0002_0000);
    wr(1, 32'h0002_0001);
    rd_chk("R7 rising enable clears total", A_TOT, 0);
    rd_chk("R7 rising enable clears master", 3, 0);
  endtask

  task automatic t_disabled();
    xfer(0, 7, 1);
    idle(10);
    rd_chk("R8 setup peak", A_TOT, 7);
    wr(1, 32'h0002_0000);
    xfer(0, 200, 10);
    idle(20);
    rd_chk("R8 total holds while off", A_TOT, 7);
    rd_chk("R8 master holds while off", 2, 7);
  endtask

  task automatic t_kib();
    wr(0, 32'd0);
    wr(1, 32'h0009_0003);     // 10-cycle windows, KiB
    xfer(0, 200, 4);
    idle(6);
    xfer(0, 200, 2);
    idle(9);
    rd_chk("R5 KiB with carried remainder", A_TOT, 1);
    rd_chk("R5 KiB master 0", 2, 1);
  endtask

  task automatic t_mib();
    wr(1, 32'h0000_0000);
    wr(1, 32'h1387_0005);     // 5000-cycle window, MiB
    xfer(3, 255, 4200);
    rd_chk("R5 MiB before close", A_TOT, 0);
    idle(850);
    rd_chk("R5 MiB total", A_TOT, 1);
    rd_chk("R5 MiB master 3", 5, 1);
  endtask

  task automatic t_sat();
    wr(1, 32'h0000_0000);
    wr(1, 32'h001D_0007);     // 30-cycle window, unit code 3 counts bytes
    xfer(0, 255, 17);
    idle(20);
    rd_chk("R9 saturated window sum (R5 code 3 as bytes)", A_TOT, 32'((1 << CW) - 1));
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regmap();
    t_timing();
    t_peak();
    t_rewrite();
    t_disabled();
    t_kib();
    t_mib();
    t_sat();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all-requirements got 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule